// File: doc/BRIEF.md
# Indirect Addressing Pointer Unit

This block holds three 12-bit data-memory pointers and turns an instruction's operand address into the data address that is actually used. Each pointer has a small group of reserved operand addresses near the top of the 4 KB data space. When an access names one of these addresses, the block selects the pointer, forms the effective address under the rule that goes with that address (use as is, step after, step before, or add a signed offset), and schedules any pointer update for the next clock edge.

The effective address is screened before it leaves. If it falls on another reserved operand address, the read data must be forced to 00h and the write dropped. If an indirect write lands on a pointer's own byte register, that byte takes the data and the pointer is not stepped. Software can also load either byte of any pointer directly, and such a load beats the automatic step of that pointer in the same cycle. All access and load inputs are plain per-cycle strobes with no handshake: the block accepts one access per cycle and never applies back-pressure. The effective address and flags are combinational from the current inputs and pointer state. Pointer changes appear after the next rising clock edge.

Top module: `iap_unit`

## Requirements
- R1: After reset every pointer reads 0x000 on `ptr_flat` (pointer k at bits 12k+11:12k).
- R2: Address map: pointer k owns the eight addresses from 0xFE8-8k to 0xFEF-8k. Offset 7 is the plain operand, 6 post-increment, 5 post-decrement, 4 pre-increment, 3 indexed, 2 the pointer's high byte register, 1 its low byte register, and 0 an ordinary address. The plain operand gives the pointer value as the effective address and leaves the pointer unchanged.
- R3: The post-increment operand gives the current pointer value and the pointer becomes value+1 after the edge.
- R4: The post-decrement operand gives the current pointer value and the pointer becomes value-1 after the edge.
- R5: The pre-increment operand gives value+1 as the address and the pointer becomes value+1 after the edge.
- R6: The indexed operand gives pointer + sign-extended `wreg` (-128..127) modulo 4096 and changes no pointer.
- R7: Steps act on all 12 bits: 0x0FF+1 gives 0x100, 0xFFF+1 gives 0x000 and 0x000-1 gives 0xFFF.
- R8: If an indirect access's effective address is a reserved operand address (offsets 3..7 of any group), a read raises `rd_force_zero` and a write raises `wr_suppress`; the accessing pointer is still updated by its rule.
- R9: An indirect write whose effective address is a pointer byte register (offset 1 or 2) stores `acc_wdata` in that byte (the high byte keeps bits 3:0 only), and that pointer takes no step in that cycle.
- R10: A direct load (`dw_en`, `dw_ptr`, `dw_hi`) writes one byte, and the high byte keeps only `dw_data[3:0]`. It beats any indirect byte write and any automatic step of the same pointer in the same cycle.
- R11: An access to an address outside offsets 3..7, or with `acc_valid` low, passes `acc_addr` to `eff_addr`, keeps `ind_active` low and changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 12 | Decoded operand address of the instruction |
| acc_wdata | input | 8 | Write data of the access |
| wreg | input | 8 | Working register, the signed offset for indexed mode |
| dw_en | input | 1 | Direct pointer byte load strobe |
| dw_ptr | input | 2 | Pointer index of the direct load |
| dw_hi | input | 1 | 1 = high byte, 0 = low byte |
| dw_data | input | 8 | Direct load data |
| eff_addr | output | 12 | Effective data address |
| ind_active | output | 1 | The access uses a pointer operand |
| rd_force_zero | output | 1 | Read data must be replaced by 00h |
| wr_suppress | output | 1 | Write must be discarded |
| ptr_flat | output | 36 | All pointer values, pointer k at bits 12k+11:12k |

## Verification
Two functions can land on the same pointer in one cycle: an automatic step from a pointer operand and a byte load, either from the direct port or from an indirect write that resolves onto the pointer's own byte register. The bench provokes both cases. It runs a post-increment while the direct port loads the same pointer's high byte, and it points a pointer at its own low byte before writing through its post-decrement operand. It also repeats the first case with the load aimed at another pointer. A bench-side model built from the requirements decides the expected result: the loaded byte wins, the other byte is kept, no step is applied, and a load on a different pointer leaves the step intact.

// File: rtl/iap_pkg.sv
package iap_pkg;

  localparam int AW        = 12;
  localparam int DW        = 8;
  localparam int N_PTR     = 3;
  localparam int IW        = (N_PTR > 1) ? $clog2(N_PTR) : 1;
  localparam int HI_W      = AW - DW;
  localparam int GRP_SPAN  = 8;
  localparam int GRP_LSB   = $clog2(GRP_SPAN);
  localparam logic [AW-1:0] GRP_TOP = 12'hFE8;

  typedef enum logic [2:0] {
    K_NONE,
    K_PLAIN,
    K_POSTINC,
    K_POSTDEC,
    K_PREINC,
    K_INDEX,
    K_PHI,
    K_PLO
  } kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [IW-1:0]   idx;
  } dec_t;

  function automatic logic is_operand(input kind_e k);
    return (k == K_PLAIN) || (k == K_POSTINC) || (k == K_POSTDEC) ||
           (k == K_PREINC) || (k == K_INDEX);
  endfunction

  function automatic logic is_preg(input kind_e k);
    return (k == K_PHI) || (k == K_PLO);
  endfunction

  function automatic dec_t decode_addr(input logic [AW-1:0] a);
    dec_t          d;
    logic [AW-1:0] base;
    d.kind = K_NONE;
    d.idx  = '0;
    for (int k = 0; k < N_PTR; k++) begin
      base = GRP_TOP - AW'(GRP_SPAN * k);
      if (a[AW-1:GRP_LSB] == base[AW-1:GRP_LSB]) begin
        d.idx = IW'(k);
        case (a[GRP_LSB-1:0])
          3'd7:    d.kind = K_PLAIN;
          3'd6:    d.kind = K_POSTINC;
          3'd5:    d.kind = K_POSTDEC;
          3'd4:    d.kind = K_PREINC;
          3'd3:    d.kind = K_INDEX;
          3'd2:    d.kind = K_PHI;
          3'd1:    d.kind = K_PLO;
          default: d.kind = K_NONE;
        endcase
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/iap_decode.sv
module iap_decode
  import iap_pkg::*;
(
  input  logic [AW-1:0] addr,
  output dec_t          dec,
  output logic          operand,
  output logic          preg
);

  always_comb begin
    dec     = decode_addr(addr);
    operand = is_operand(dec.kind);
    preg    = is_preg(dec.kind);
  end

endmodule

// File: rtl/iap_agen.sv
module iap_agen
  import iap_pkg::*;
(
  input  kind_e         kind,
  input  logic [AW-1:0] ptr_val,
  input  logic [DW-1:0] offset,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] next_val,
  output logic          upd
);

  logic [AW-1:0] inc_val;
  logic [AW-1:0] dec_val;
  logic [AW-1:0] sext_off;

  assign inc_val  = ptr_val + AW'(1);
  assign dec_val  = ptr_val - AW'(1);
  assign sext_off = {{(AW-DW){offset[DW-1]}}, offset};

  always_comb begin
    addr     = ptr_val;
    next_val = ptr_val;
    upd      = 1'b0;
    unique case (kind)
      K_POSTINC: begin
        next_val = inc_val;
        upd      = 1'b1;
      end
      K_POSTDEC: begin
        next_val = dec_val;
        upd      = 1'b1;
      end
      K_PREINC: begin
        addr     = inc_val;
        next_val = inc_val;
        upd      = 1'b1;
      end
      K_INDEX: begin
        addr = ptr_val + sext_off;
      end
      default: begin
        addr = ptr_val;
      end
    endcase
  end

endmodule

// File: rtl/iap_ptr_reg.sv
module iap_ptr_reg
  import iap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_val,
  input  logic          dir_lo_we,
  input  logic          dir_hi_we,
  input  logic [DW-1:0] dir_data,
  input  logic          ind_lo_we,
  input  logic          ind_hi_we,
  input  logic [DW-1:0] ind_data,
  output logic [AW-1:0] q
);

  logic            any_we;
  logic [DW-1:0]   lo_nxt;
  logic [HI_W-1:0] hi_nxt;
  logic            unused_upper;

  assign any_we       = dir_lo_we | dir_hi_we | ind_lo_we | ind_hi_we;
  assign unused_upper = ^{dir_data[DW-1:HI_W], ind_data[DW-1:HI_W]};

  always_comb begin
    lo_nxt = q[DW-1:0];
    hi_nxt = q[AW-1:DW];
    if (any_we) begin
      if (dir_lo_we)      lo_nxt = dir_data;
      else if (ind_lo_we) lo_nxt = ind_data;
      if (dir_hi_we)      hi_nxt = dir_data[HI_W-1:0];
      else if (ind_hi_we) hi_nxt = ind_data[HI_W-1:0];
    end else if (upd_en) begin
      lo_nxt = upd_val[DW-1:0];
      hi_nxt = upd_val[AW-1:DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {hi_nxt, lo_nxt};
  end

  AST_DIRECT_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dir_lo_we |=> q[DW-1:0] == $past(dir_data)); // R10
  AST_DIRECT_HI_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_hi_we |=> q[AW-1:DW] == $past(dir_data[HI_W-1:0])); // R10
  AST_SELF_WRITE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_lo_we && !dir_lo_we) |=> q[DW-1:0] == $past(ind_data)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_we && !upd_en) |=> $stable(q)); // R2

endmodule

// File: rtl/iap_unit.sv
module iap_unit
  import iap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [AW-1:0]       acc_addr,
  input  logic [DW-1:0]       acc_wdata,
  input  logic [DW-1:0]       wreg,
  input  logic                dw_en,
  input  logic [IW-1:0]       dw_ptr,
  input  logic                dw_hi,
  input  logic [DW-1:0]       dw_data,
  output logic [AW-1:0]       eff_addr,
  output logic                ind_active,
  output logic                rd_force_zero,
  output logic                wr_suppress,
  output logic [N_PTR*AW-1:0] ptr_flat
);

  logic [AW-1:0] ptr_q [N_PTR];

  dec_t          op_dec;
  logic          op_is_operand;
  logic          op_is_preg;
  dec_t          tg_dec;
  logic          tg_is_operand;
  logic          tg_is_preg;
  logic [AW-1:0] sel_ptr;
  logic [AW-1:0] gen_addr;
  logic [AW-1:0] gen_next;
  logic          gen_upd;
  logic          ind_bw;
  logic          own_touch;

  iap_decode u_op_dec (
    .addr    (acc_addr),
    .dec     (op_dec),
    .operand (op_is_operand),
    .preg    (op_is_preg)
  );

  assign sel_ptr    = ptr_q[op_dec.idx];
  assign ind_active = acc_valid & op_is_operand;

  iap_agen u_agen (
    .kind     (op_dec.kind),
    .ptr_val  (sel_ptr),
    .offset   (wreg),
    .addr     (gen_addr),
    .next_val (gen_next),
    .upd      (gen_upd)
  );

  iap_decode u_tg_dec (
    .addr    (gen_addr),
    .dec     (tg_dec),
    .operand (tg_is_operand),
    .preg    (tg_is_preg)
  );

  assign eff_addr      = ind_active ? gen_addr : acc_addr;
  assign rd_force_zero = ind_active & ~acc_write & tg_is_operand;
  assign wr_suppress   = ind_active &  acc_write & tg_is_operand;
  assign ind_bw        = ind_active &  acc_write & tg_is_preg;

  logic unused_op_preg;
  assign unused_op_preg = op_is_preg;

  for (genvar k = 0; k < N_PTR; k++) begin : g_ptr
    logic sel_here;
    logic tgt_here;
    logic dir_here;
    assign sel_here = (op_dec.idx == IW'(k));
    assign tgt_here = ind_bw & (tg_dec.idx == IW'(k));
    assign dir_here = dw_en & (dw_ptr == IW'(k));

    iap_ptr_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (ind_active & gen_upd & sel_here),
      .upd_val   (gen_next),
      .dir_lo_we (dir_here & ~dw_hi),
      .dir_hi_we (dir_here &  dw_hi),
      .dir_data  (dw_data),
      .ind_lo_we (tgt_here & (tg_dec.kind == K_PLO)),
      .ind_hi_we (tgt_here & (tg_dec.kind == K_PHI)),
      .ind_data  (acc_wdata),
      .q         (ptr_q[k])
    );

    assign ptr_flat[k*AW +: AW] = ptr_q[k];
  end

  assign own_touch = (dw_en && (dw_ptr == op_dec.idx)) ||
                     (ind_bw && (tg_dec.idx == op_dec.idx));

  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_active && op_dec.kind == K_POSTINC && !own_touch)
      |=> ptr_q[$past(op_dec.idx)] == $past(sel_ptr) + AW'(1)); // R3
  AST_POSTDEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_active && op_dec.kind == K_POSTDEC && !own_touch)
      |=> ptr_q[$past(op_dec.idx)] == $past(sel_ptr) - AW'(1)); // R4
  AST_ZERO_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_force_zero |-> (acc_valid && !acc_write)); // R8
  AST_SUPPRESS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_force_zero && wr_suppress)); // R8
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (eff_addr == acc_addr && !rd_force_zero && !wr_suppress)); // R11

endmodule

// File: tb/sim_iap_unit.sv
module sim_iap_unit;

  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_write;
  logic [11:0] acc_addr;
  logic [7:0]  acc_wdata;
  logic [7:0]  wreg;
  logic        dw_en;
  logic [1:0]  dw_ptr;
  logic        dw_hi;
  logic [7:0]  dw_data;
  logic [11:0] eff_addr;
  logic        ind_active;
  logic        rd_force_zero;
  logic        wr_suppress;
  logic [35:0] ptr_flat;

  int n_chk;
  int n_bad;
  logic [11:0] m_ptr [3];

  iap_unit u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_addr      (acc_addr),
    .acc_wdata     (acc_wdata),
    .wreg          (wreg),
    .dw_en         (dw_en),
    .dw_ptr        (dw_ptr),
    .dw_hi         (dw_hi),
    .dw_data       (dw_data),
    .eff_addr      (eff_addr),
    .ind_active    (ind_active),
    .rd_force_zero (rd_force_zero),
    .wr_suppress   (wr_suppress),
    .ptr_flat      (ptr_flat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [35:0] got, input logic [35:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Address map of R2: group k spans 0xFE8-8k .. 0xFEF-8k.
  // kind: 0 ordinary, 1 plain, 2 postinc, 3 postdec, 4 preinc, 5 indexed, 6 hi reg, 7 lo reg
  function automatic void map(input logic [11:0] a, output int kind, output int idx);
    logic [11:0] base;
    kind = 0;
    idx  = 0;
    for (int i = 0; i < 3; i++) begin
      base = 12'hFE8 - 12'(8 * i);
      if (a[11:3] == base[11:3]) begin
        idx = i;
        case (a[2:0])
          3'd7: kind = 1;
          3'd6: kind = 2;
          3'd5: kind = 3;
          3'd4: kind = 4;
          3'd3: kind = 5;
          3'd2: kind = 6;
          3'd1: kind = 7;
          default: kind = 0;
        endcase
      end
    end
  endfunction

  function automatic logic [35:0] model_flat();
    return {m_ptr[2], m_ptr[1], m_ptr[0]};
  endfunction

  task automatic step(input string req, input logic v, input logic wr,
                      input logic [11:0] a, input logic [7:0] wd, input logic [7:0] w,
                      input logic de, input logic [1:0] dp, input logic dh,
                      input logic [7:0] dd);
    int k, i, tk, ti;
    logic        ind, upd, ibw, erz, ews;
    logic [11:0] p, eff, nv, newv;
    @(negedge clk);
    acc_valid = v; acc_write = wr; acc_addr = a; acc_wdata = wd; wreg = w;
    dw_en = de; dw_ptr = dp; dw_hi = dh; dw_data = dd;
    map(a, k, i);
    ind = v && (k >= 1) && (k <= 5);
    p   = m_ptr[i];
    eff = a; nv = p; upd = 1'b0;
    if (ind) begin
      case (k)
        1: eff = p;
        2: begin eff = p; nv = p + 12'd1; upd = 1'b1; end
        3: begin eff = p; nv = p - 12'd1; upd = 1'b1; end
        4: begin eff = p + 12'd1; nv = p + 12'd1; upd = 1'b1; end
        default: eff = p + {{4{w[7]}}, w};
      endcase
    end
    map(eff, tk, ti);
    erz = ind && !wr && (tk >= 1) && (tk <= 5);
    ews = ind &&  wr && (tk >= 1) && (tk <= 5);
    ibw = ind &&  wr && (tk == 6 || tk == 7);
    #3;
    chk(req, "eff_addr", 36'(eff_addr), 36'(eff));
    chk(req, "ind_active", 36'(ind_active), 36'(ind));
    chk(req, "rd_force_zero", 36'(rd_force_zero), 36'(erz));
    chk(req, "wr_suppress", 36'(wr_suppress), 36'(ews));
    for (int j = 0; j < 3; j++) begin
      logic touched;
      newv = m_ptr[j];
      touched = 1'b0;
      if (ibw && ti == j) begin
        touched = 1'b1;
        if (tk == 7) newv[7:0]  = wd;
        else         newv[11:8] = wd[3:0];
      end
      if (de && dp == 2'(j)) begin
        touched = 1'b1;
        if (!dh) newv[7:0]  = dd;
        else     newv[11:8] = dd[3:0];
      end
      if (!touched && upd && i == j) newv = nv;
      m_ptr[j] = newv;
    end
    @(posedge clk);
    #2;
    chk(req, "ptr_flat", ptr_flat, model_flat());
  endtask

  task automatic idle_cycle();
    step("R11", 1'b0, 1'b0, 12'h000, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
  endtask

  task automatic load_ptr(input int n, input logic [11:0] val);
    step("R10", 1'b0, 1'b0, 12'h000, 8'h00, 8'h00, 1'b1, 2'(n), 1'b0, val[7:0]);
    step("R10", 1'b0, 1'b0, 12'h000, 8'h00, 8'h00, 1'b1, 2'(n), 1'b1, {4'hA, val[11:8]});
  endtask

  task automatic t_reset();
    #3;
    chk("R1", "ptr_flat after reset", ptr_flat, 36'h0);
    chk("R1", "eff_addr idle", 36'(eff_addr), 36'h0);
  endtask

  task automatic t_plain();
    load_ptr(0, 12'h123);
    step("R2", 1'b1, 1'b0, 12'hFEF, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    chk("R2", "plain effective literal", 36'(eff_addr), 36'h123);
    chk("R2", "plain keeps pointer", 36'(ptr_flat[11:0]), 36'h123);
  endtask

  task automatic t_postinc();
    load_ptr(1, 12'h0FF);
    step("R3", 1'b1, 1'b0, 12'hFE6, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    chk("R7", "low byte carry", 36'(ptr_flat[23:12]), 36'h100);
    step("R3", 1'b1, 1'b1, 12'hFE6, 8'h11, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
  endtask

  task automatic t_postdec();
    load_ptr(2, 12'h000);
    step("R4", 1'b1, 1'b0, 12'hFDD, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    chk("R7", "borrow wraps to 0xFFF", 36'(ptr_flat[35:24]), 36'hFFF);
    load_ptr(2, 12'h300);
    step("R4", 1'b1, 1'b0, 12'hFDD, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
  endtask

  task automatic t_preinc();
    load_ptr(0, 12'hFFF);
    step("R5", 1'b1, 1'b0, 12'hFEC, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    chk("R7", "0xFFF steps to 0x000", 36'(ptr_flat[11:0]), 36'h000);
    load_ptr(0, 12'h07F);
    step("R5", 1'b1, 1'b0, 12'hFEC, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
  endtask

  task automatic t_index();
    load_ptr(1, 12'h010);
    step("R6", 1'b1, 1'b0, 12'hFE3, 8'h00, 8'hF0, 1'b0, 2'd0, 1'b0, 8'h00);
    step("R6", 1'b1, 1'b0, 12'hFE3, 8'h00, 8'h80, 1'b0, 2'd0, 1'b0, 8'h00);
    step("R6", 1'b1, 1'b0, 12'hFE3, 8'h00, 8'h7F, 1'b0, 2'd0, 1'b0, 8'h00);
    chk("R6", "indexed keeps pointer", 36'(ptr_flat[23:12]), 36'h010);
  endtask

  task automatic t_virtual();
    load_ptr(0, 12'hFE7);
    step("R8", 1'b1, 1'b0, 12'hFEF, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    step("R8", 1'b1, 1'b1, 12'hFEF, 8'h5A, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    step("R8", 1'b1, 1'b0, 12'hFEE, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    chk("R8", "pointer still stepped", 36'(ptr_flat[11:0]), 36'hFE8);
    load_ptr(2, 12'hFD0);
    step("R8", 1'b1, 1'b1, 12'hFDB, 8'h33, 8'h03, 1'b0, 2'd0, 1'b0, 8'h00);
  endtask

  task automatic t_self_write();
    load_ptr(2, 12'hFD9);
    step("R9", 1'b1, 1'b1, 12'hFDD, 8'h55, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    chk("R9", "own low byte, no step", 36'(ptr_flat[35:24]), 36'hF55);
    load_ptr(1, 12'hFDA);
    step("R9", 1'b1, 1'b1, 12'hFE6, 8'hAB, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    chk("R9", "other pointer high nibble", 36'(ptr_flat[35:24]), 36'hB55);
  endtask

  task automatic t_direct_prio();
    load_ptr(0, 12'h0FF);
    step("R10", 1'b1, 1'b0, 12'hFEE, 8'h00, 8'h00, 1'b1, 2'd0, 1'b1, 8'h37);
    chk("R10", "load beats step", 36'(ptr_flat[11:0]), 36'h7FF);
    step("R10", 1'b1, 1'b0, 12'hFEE, 8'h00, 8'h00, 1'b1, 2'd1, 1'b0, 8'h44);
    load_ptr(2, 12'hFD9);
    step("R10", 1'b1, 1'b1, 12'hFDD, 8'h66, 8'h00, 1'b1, 2'd2, 1'b0, 8'h99);
    chk("R10", "direct beats indirect byte", 36'(ptr_flat[35:24]), 36'hF99);
  endtask

  task automatic t_passthru();
    step("R11", 1'b1, 1'b0, 12'h123, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    step("R11", 1'b1, 1'b1, 12'hFE8, 8'hFF, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    step("R11", 1'b1, 1'b1, 12'hFEA, 8'h12, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
    step("R11", 1'b0, 1'b0, 12'hFEE, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00);
  endtask

  bit finished;

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    for (int j = 0; j < 3; j++) m_ptr[j] = 12'h000;
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_wdata = '0; wreg = '0;
    dw_en = 1'b0; dw_ptr = '0; dw_hi = 1'b0; dw_data = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_postinc();
    t_postdec();
    t_preinc();
    t_index();
    t_virtual();
    t_self_write();
    t_direct_prio();
    t_passthru();
    idle_cycle();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule